// File: doc/BRIEF.md
# Auxiliary External Interrupt Controller

This block adds two extra external interrupt sources to an 8051-class core. Each source watches one active-low pin, keeps a pending flag, and presents a request and a priority level to the core's interrupt arbiter. The four controls of each source sit together in one bit-addressable 8-bit control register: trigger type, pending flag, enable and priority level. The core can reach that register as a whole byte or one bit at a time.

Each pin passes through a synchroniser before it is used. A source whose trigger bit is 1 sets its flag on a falling edge. The flag then stays set until the arbiter acknowledges the interrupt or software clears it. A source whose trigger bit is 0 is level-sensitive: its flag follows the inverted pin and ignores both acknowledge and software. The request to the arbiter is the flag gated by the enable bit.

The register port and the bit port are single-cycle control interfaces with no back-pressure: a write takes effect at the clock edge on which its strobe is sampled, and read data is combinational from the address. Vector generation and arbitration between sources belong to the core.

Top module: `xirq_ctrl`

## Requirements
- R1: A read with `sfr_addr` = 0xC0 returns the control register combinationally, with bit 7 = priority of source 1, bit 6 = enable 1, bit 5 = flag 1, bit 4 = trigger 1, bit 3 = priority 0, bit 2 = enable 0, bit 1 = flag 0 and bit 0 = trigger 0. Any other address reads as 0x00.
- R2: A byte write (`sfr_wr` with `sfr_addr` = 0xC0) loads all eight bits at the next clock edge, except a flag whose source is in level mode. A byte write to any other address changes nothing.
- R3: A bit write (`bit_wr`) to bit address 0xC0+k, for k = 0 to 7, loads `bit_wdata` into register bit k only. A bit write to any bit address outside 0xC0 to 0xC7 changes nothing. When both strobes are active in the same cycle, the byte write wins.
- R4: In edge mode (trigger = 1), a falling edge on `xint_n[i]` sets flag i on the third rising clock edge after the pin changes. A pin that stays low sets the flag only once.
- R5: In edge mode, `irq_ack[i]` clears flag i at the next clock edge. If a detected edge falls on the same clock edge, the flag stays set.
- R6: In level mode (trigger = 0), flag i equals the inverted pin level, delayed by three rising clock edges. Both `irq_ack[i]` and software writes to that flag have no effect on it.
- R7: In edge mode, a software write to a flag bit sets or clears it like hardware would. A detected edge takes precedence over a software clear on the same clock edge.
- R8: `irq_req[i]` is 1 exactly when flag i and enable i are both 1.
- R9: `irq_hi[i]` equals priority bit i.
- R10: Reset clears all eight register bits, so both sources start in level mode with no request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xint_n | input | 2 | External interrupt pins, active low, asynchronous |
| sfr_addr | input | 8 | Register address for byte reads and writes |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_rdata | output | 8 | Combinational read data |
| bit_addr | input | 8 | Bit address for single-bit writes |
| bit_wr | input | 1 | Bit write strobe |
| bit_wdata | input | 1 | Bit write value |
| irq_ack | input | 2 | Interrupt serviced pulse from the arbiter, one per source |
| irq_req | output | 2 | Enabled request to the arbiter, one per source |
| irq_hi | output | 2 | Priority level per source, 1 = high |

## Verification
The hardest situation to reach is a collision on the flag at a single clock edge: an edge detection arriving together with an acknowledge or a software clear. Detection happens three clock edges after the pin moves, so the stimulus lowers the pin and then raises the acknowledge or the write strobe exactly two cycles later. A behavioural reference model, which keeps the recent pin history and the register contents, is compared with the outputs on every clock. A random phase with frequent pin toggles, acknowledges and writes then produces many more such collisions, including trigger-mode changes while a flag is set.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int FIELDS_PER_SRC = 4;

  // Field order inside one source's nibble, MSB first
  typedef struct packed {
    logic pri;
    logic en;
    logic flag;
    logic trig;
  } src_ctl_t;

  localparam int F_TRIG = 0;
  localparam int F_FLAG = 1;
  localparam int F_EN   = 2;
  localparam int F_PRI  = 3;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int N_PIN  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PIN-1:0] pin_n,
  output logic [N_PIN-1:0] now_n,
  output logic [N_PIN-1:0] prev_n
);
  logic [N_PIN-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '1;
      prev_n <= '1;
    end else begin
      chain[0] <= pin_n;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev_n <= chain[STAGES-1];
    end
  end

  assign now_n = chain[STAGES-1];
endmodule

// File: rtl/xirq_regif.sv
module xirq_regif #(
  parameter int               ADDR_W   = 8,
  parameter int               REG_W    = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'hC0
) (
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [REG_W-1:0]  sfr_wdata,
  output logic [REG_W-1:0]  sfr_rdata,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              bit_wr,
  input  logic              bit_wdata,
  input  logic [REG_W-1:0]  ctl,
  output logic [REG_W-1:0]  wr_mask,
  output logic [REG_W-1:0]  wr_val
);
  localparam int IDX_W = $clog2(REG_W);

  logic byte_hit;
  logic bit_hit;

  assign byte_hit = sfr_wr && (sfr_addr == CTL_ADDR);
  assign bit_hit  = bit_wr && (bit_addr[ADDR_W-1:IDX_W] == CTL_ADDR[ADDR_W-1:IDX_W]);

  for (genvar k = 0; k < REG_W; k++) begin : g_bit
    assign wr_mask[k] = byte_hit || (bit_hit && (bit_addr[IDX_W-1:0] == IDX_W'(k)));
    assign wr_val[k]  = byte_hit ? sfr_wdata[k] : bit_wdata;
  end

  assign sfr_rdata = (sfr_addr == CTL_ADDR) ? ctl : '0;
endmodule

// File: rtl/xirq_src.sv
module xirq_src
  import xirq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fall,
  input  logic     active,
  input  logic     ack,
  input  src_ctl_t wmask,
  input  src_ctl_t wval,
  output src_ctl_t ctl,
  output logic     req,
  output logic     hi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      if (wmask.trig) ctl.trig <= wval.trig;
      if (wmask.en)   ctl.en   <= wval.en;
      if (wmask.pri)  ctl.pri  <= wval.pri;
      // mode is taken from the trigger bit held before this edge
      if (!ctl.trig)       ctl.flag <= active;
      else if (fall)       ctl.flag <= 1'b1;
      else if (wmask.flag) ctl.flag <= wval.flag;
      else if (ack)        ctl.flag <= 1'b0;
    end
  end

  assign req = ctl.flag & ctl.en;
  assign hi  = ctl.pri;
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int               N_SRC       = 2,
  parameter int               SYNC_STAGES = 2,
  parameter int               ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR    = 8'hC0,
  localparam int              REG_W       = N_SRC * FIELDS_PER_SRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  xint_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [REG_W-1:0]  sfr_wdata,
  output logic [REG_W-1:0]  sfr_rdata,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              bit_wr,
  input  logic              bit_wdata,
  input  logic [N_SRC-1:0]  irq_ack,
  output logic [N_SRC-1:0]  irq_req,
  output logic [N_SRC-1:0]  irq_hi
);
  logic [N_SRC-1:0] sync_now;
  logic [N_SRC-1:0] sync_prev;
  logic [REG_W-1:0] ctl_q;
  logic [REG_W-1:0] wr_mask;
  logic [REG_W-1:0] wr_val;

  xirq_sync #(.N_PIN(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_n  (xint_n),
    .now_n  (sync_now),
    .prev_n (sync_prev)
  );

  xirq_regif #(.ADDR_W(ADDR_W), .REG_W(REG_W), .CTL_ADDR(CTL_ADDR)) u_regif (
    .sfr_addr  (sfr_addr),
    .sfr_wr    (sfr_wr),
    .sfr_wdata (sfr_wdata),
    .sfr_rdata (sfr_rdata),
    .bit_addr  (bit_addr),
    .bit_wr    (bit_wr),
    .bit_wdata (bit_wdata),
    .ctl       (ctl_q),
    .wr_mask   (wr_mask),
    .wr_val    (wr_val)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    src_ctl_t src_ctl;

    xirq_src u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .fall   (sync_prev[g] & ~sync_now[g]),
      .active (~sync_now[g]),
      .ack    (irq_ack[g]),
      .wmask  (wr_mask[g*FIELDS_PER_SRC +: FIELDS_PER_SRC]),
      .wval   (wr_val[g*FIELDS_PER_SRC +: FIELDS_PER_SRC]),
      .ctl    (src_ctl),
      .req    (irq_req[g]),
      .hi     (irq_hi[g])
    );

    assign ctl_q[g*FIELDS_PER_SRC +: FIELDS_PER_SRC] = src_ctl;
  end
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk
  import xirq_pkg::*;
#(
  parameter int               N_SRC    = 2,
  parameter int               ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'hC0,
  localparam int              REG_W    = N_SRC * FIELDS_PER_SRC,
  localparam int              IDX_W    = $clog2(REG_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic              sfr_wr,
  input logic [ADDR_W-1:0] bit_addr,
  input logic              bit_wr,
  input logic [N_SRC-1:0]  irq_ack,
  input logic [N_SRC-1:0]  irq_req,
  input logic [N_SRC-1:0]  irq_hi,
  input logic [REG_W-1:0]  ctl,
  input logic [N_SRC-1:0]  sync_now,
  input logic [N_SRC-1:0]  sync_prev
);
  logic [REG_W-1:0] flag_mask;
  logic             byte_hit;
  logic             foreign_bit;

  always_comb begin
    flag_mask = '0;
    for (int i = 0; i < N_SRC; i++) flag_mask[i*FIELDS_PER_SRC + F_FLAG] = 1'b1;
  end

  assign byte_hit    = sfr_wr && (sfr_addr == CTL_ADDR);
  assign foreign_bit = !bit_wr || (bit_addr[ADDR_W-1:IDX_W] != CTL_ADDR[ADDR_W-1:IDX_W]);

  AST_FOREIGN_BIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_hit && foreign_bit) |=> $stable(ctl & ~flag_mask)); // R3

  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    localparam int T = g*FIELDS_PER_SRC + F_TRIG;
    localparam int F = g*FIELDS_PER_SRC + F_FLAG;
    localparam int E = g*FIELDS_PER_SRC + F_EN;
    localparam int P = g*FIELDS_PER_SRC + F_PRI;

    logic fall_seen;
    logic flag_wr;
    assign fall_seen = sync_prev[g] && !sync_now[g];
    assign flag_wr   = byte_hit || (bit_wr && (bit_addr == CTL_ADDR + ADDR_W'(F)));

    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[T] && fall_seen) |=> ctl[F]); // R4
    AST_EDGE_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[T] && !fall_seen && !irq_ack[g] && !flag_wr) |=> $stable(ctl[F])); // R4
    AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[T] && irq_ack[g] && !fall_seen && !flag_wr) |=> !ctl[F]); // R5
    AST_LEVEL_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl[T] |=> (ctl[F] == !$past(sync_now[g]))); // R6
    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[g] |-> (ctl[E] && ctl[F])); // R8
    AST_HI_FROM_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hi[g] |-> ctl[P]); // R9
  end
endmodule

bind xirq_ctrl xirq_ctrl_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sfr_addr  (sfr_addr),
  .sfr_wr    (sfr_wr),
  .bit_addr  (bit_addr),
  .bit_wr    (bit_wr),
  .irq_ack   (irq_ack),
  .irq_req   (irq_req),
  .irq_hi    (irq_hi),
  .ctl       (ctl_q),
  .sync_now  (sync_now),
  .sync_prev (sync_prev)
);

// File: tb/xirq_ctrl_tb_top.sv
`timescale 1ns/100ps
module xirq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] xint_n = 2'b11;
  logic [7:0] sfr_addr = 8'h00;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic [7:0] bit_addr = 8'h00;
  logic       bit_wr = 1'b0;
  logic       bit_wdata = 1'b0;
  logic [1:0] irq_ack = 2'b00;
  logic [1:0] irq_req;
  logic [1:0] irq_hi;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  xirq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .xint_n(xint_n),
    .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .bit_addr(bit_addr), .bit_wr(bit_wr), .bit_wdata(bit_wdata),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_hi(irq_hi)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  // Behavioural reference model: pin history list plus register image
  logic [7:0] m_ctl;
  logic [1:0] m_hist [3];
  logic [7:0] m_next;
  logic       m_byte;
  logic       m_bit;
  logic       m_fwr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = 8'h00;
      for (int j = 0; j < 3; j++) m_hist[j] = 2'b11;
    end else begin
      m_byte = sfr_wr && sfr_addr == 8'hC0;
      m_bit  = bit_wr && bit_addr >= 8'hC0 && bit_addr <= 8'hC7;
      m_next = m_ctl;
      if (m_byte) m_next = sfr_wdata;
      else if (m_bit) m_next[bit_addr - 8'hC0] = bit_wdata;
      for (int i = 0; i < 2; i++) begin
        m_fwr = m_byte || (m_bit && bit_addr == 8'hC1 + 8'(i*4));
        if (m_ctl[i*4] == 1'b0)                      m_next[i*4+1] = ~m_hist[1][i];
        else if (m_hist[2][i] && !m_hist[1][i])      m_next[i*4+1] = 1'b1;
        else if (m_fwr)                              m_next[i*4+1] = m_next[i*4+1];
        else if (irq_ack[i])                         m_next[i*4+1] = 1'b0;
        else                                         m_next[i*4+1] = m_ctl[i*4+1];
      end
      m_ctl = m_next;
      m_hist[2] = m_hist[1];
      m_hist[1] = m_hist[0];
      m_hist[0] = xint_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 irq_req vs model", {6'd0, irq_req}, {6'd0, m_ctl[6] & m_ctl[5], m_ctl[2] & m_ctl[1]});
      chk("R9 irq_hi vs model", {6'd0, irq_hi}, {6'd0, m_ctl[7], m_ctl[3]});
      chk("R1 sfr_rdata vs model", sfr_rdata, (sfr_addr == 8'hC0) ? m_ctl : 8'h00);
    end
  end

  task automatic tick();
    @(negedge clk);
    #0.5;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    tick();
    sfr_wr = 1'b0; sfr_addr = 8'hC0;
  endtask

  task automatic wr_bit(input logic [7:0] a, input logic v);
    bit_addr = a; bit_wdata = v; bit_wr = 1'b1;
    tick();
    bit_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] exp);
    sfr_addr = 8'hC0;
    #0.5;
    chk(tag, sfr_rdata, exp);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    ticks(3);
    rst_n = 1'b1;
    tick();
    rd_chk("R10 register after reset", 8'h00);
    chk("R10 no request after reset", {6'd0, irq_req}, 8'h00);

    // source 1 level mode, flag write ignored; source 0 edge mode enabled
    wr_byte(8'hC0, 8'hE5);
    rd_chk("R2 R6 byte write, level flag ignored", 8'hC5);

    // falling edge on source 0
    xint_n[0] = 1'b0;
    ticks(2);
    rd_chk("R4 flag not yet set after two edges", 8'hC5);
    tick();
    rd_chk("R4 flag set on third edge", 8'hC7);
    chk("R8 request for source 0", {6'd0, irq_req}, 8'h01);
    ticks(3);
    rd_chk("R4 steady low keeps one flag", 8'hC7);
    irq_ack[0] = 1'b1; tick(); irq_ack[0] = 1'b0;
    rd_chk("R5 acknowledge clears edge flag", 8'hC5);
    ticks(3);
    rd_chk("R4 low level does not set again", 8'hC5);

    // edge detection collides with acknowledge
    xint_n[0] = 1'b1; ticks(3);
    xint_n[0] = 1'b0; ticks(2);
    irq_ack[0] = 1'b1; tick(); irq_ack[0] = 1'b0;
    rd_chk("R5 edge wins over acknowledge", 8'hC7);

    // software clear and set
    wr_bit(8'hC1, 1'b0);
    rd_chk("R7 software clear of edge flag", 8'hC5);
    wr_bit(8'hC1, 1'b1);
    rd_chk("R7 software set of edge flag", 8'hC7);
    chk("R7 request after software set", {6'd0, irq_req}, 8'h01);

    // enable and priority
    wr_bit(8'hC2, 1'b0);
    rd_chk("R3 clear enable 0", 8'hC3);
    chk("R8 disabled source gives no request", {6'd0, irq_req}, 8'h00);
    wr_bit(8'hC3, 1'b1);
    chk("R9 both priorities high", {6'd0, irq_hi}, 8'h03);
    wr_bit(8'hC7, 1'b0);
    rd_chk("R3 clear priority 1", 8'h4B);
    chk("R9 priority 1 low", {6'd0, irq_hi}, 8'h01);

    // level mode on source 1
    xint_n[1] = 1'b0; ticks(3);
    rd_chk("R6 level flag follows low pin", 8'h6B);
    chk("R8 level request source 1", {6'd0, irq_req}, 8'h02);
    irq_ack[1] = 1'b1; tick(); irq_ack[1] = 1'b0;
    rd_chk("R6 acknowledge ignored in level mode", 8'h6B);
    wr_bit(8'hC5, 1'b0);
    rd_chk("R6 software clear ignored in level mode", 8'h6B);
    xint_n[1] = 1'b1; ticks(2);
    rd_chk("R6 level flag still set before latency", 8'h6B);
    tick();
    rd_chk("R6 level flag drops with pin", 8'h4B);

    // accesses that must not touch the register
    wr_bit(8'hC8, 1'b1);
    rd_chk("R3 bit address above range ignored", 8'h4B);
    wr_bit(8'hB8, 1'b1);
    rd_chk("R3 bit address below range ignored", 8'h4B);
    wr_byte(8'hC1, 8'hFF);
    rd_chk("R2 byte write to other address ignored", 8'h4B);
    sfr_addr = 8'hC1; #0.5;
    chk("R1 other address reads zero", sfr_rdata, 8'h00);
    sfr_addr = 8'hC0;
    wr_bit(8'hC6, 1'b0);
    rd_chk("R3 bit write touches only enable 1", 8'h0B);
    wr_bit(8'hC0, 1'b0);
    tick();
    rd_chk("R3 trigger 0 to level keeps low-pin flag", 8'h0A);

    // random phase compared against the model each clock
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if ($urandom_range(0, 3) == 0) xint_n[0] = ~xint_n[0];
      if ($urandom_range(0, 3) == 0) xint_n[1] = ~xint_n[1];
      irq_ack   = 2'($urandom_range(0, 3));
      sfr_addr  = ($urandom_range(0, 4) == 0) ? 8'hC1 : 8'hC0;
      sfr_wr    = (r < 8);
      sfr_wdata = 8'($urandom);
      bit_wr    = (r >= 8 && r < 40);
      bit_addr  = 8'hBE + 8'($urandom_range(0, 11));
      bit_wdata = 1'($urandom);
      tick();
    end
    sfr_wr = 1'b0; bit_wr = 1'b0; irq_ack = 2'b00;
    ticks(4);

    summary();
    $finish;
  end
endmodule